// File: doc/BRIEF.md
# Paged Program Counter with Return Stack

This block is the instruction-sequencing unit of a small processor with a 13-bit program address space. It holds the program counter and presents it as the fetch address. It also holds an 8-entry hardware stack of return addresses. Each instruction cycle the decoder raises at most one command strobe. The commands are: advance, taken skip, jump, call, plain return, return with a literal, and return from interrupt. Together with the strobe the decoder supplies an 11-bit immediate, the 5-bit page latch register and an 8-bit literal.

A jump or call target is built from two parts. The 11-bit immediate supplies the low bits. The two page bits come from positions 4:3 of the page latch. Every change of flow takes two instruction cycles. In the second cycle, called the bubble, the unit executes a NOP: it holds the fetch address and ignores every strobe. A taken skip works the same way. The instruction after the skip is discarded and a NOP runs in its place. The return-with-literal command pulses a load strobe for the working register and carries the literal with it. The return-from-interrupt command pulses a strobe that sets the global interrupt enable.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the unit returns to this state: fetch address 0, no bubble, all 8 stack entries 0 and the stack pointer at the first slot.
- R2: An advance sets the fetch address to the old value plus 1, modulo 2^13, so 1FFFh is followed by 0000h. No bubble follows.
- R3: A jump loads `imm_i[10:0]` into fetch-address bits 10:0 and `page_i[4:3]` into bits 12:11. The next cycle is a bubble.
- R4: A call pushes the old fetch address plus 1 (modulo 2^13) onto the stack. It then loads the same target as a jump, and the next cycle is a bubble.
- R5: A plain return pops the top of the stack into the fetch address. The next cycle is a bubble.
- R6: A return with a literal raises `wload_o` in the same cycle, with `wlit_o` equal to `lit_i`; `wlit_o` is 0 whenever `wload_o` is low. It then pops the stack into the fetch address, and the next cycle is a bubble.
- R7: A return from interrupt raises `gie_set_o` in the same cycle. It then pops the stack into the fetch address, and the next cycle is a bubble.
- R8: A taken skip sets the fetch address to the old value plus 2, modulo 2^13. The next cycle is a bubble, which stands in for the discarded instruction.
- R9: A bubble lasts exactly one cycle. During it every strobe is ignored: the fetch address is held, the stack is unchanged, and `wload_o` and `gie_set_o` stay low.
- R10: When several strobes are high together, only the one with the highest priority acts. The order, from highest, is: return from interrupt, return with literal, plain return, call, jump, skip, advance.
- R11: With no strobe high outside a bubble, the fetch address is held and no bubble follows.
- R12: The stack is circular with 8 entries. A push onto a full stack overwrites the oldest entry. A pop from an empty stack wraps around and returns the entry in the slot below the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance strobe |
| skip_i | input | 1 | Taken-skip strobe |
| jump_i | input | 1 | Jump strobe |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Plain return strobe |
| retlit_i | input | 1 | Return-with-literal strobe |
| retint_i | input | 1 | Return-from-interrupt strobe |
| imm_i | input | 11 | Immediate target bits for jump and call |
| page_i | input | 5 | Page latch register; bits 4:3 are used |
| lit_i | input | 8 | Literal for return with literal |
| fetch_addr_o | output | 13 | Program counter, the current fetch address |
| wload_o | output | 1 | Working-register load strobe |
| wlit_o | output | 8 | Literal to load, 0 when not loading |
| gie_set_o | output | 1 | Global interrupt enable set strobe |
| bubble_o | output | 1 | The current cycle executes a NOP |

## Verification
A behavioural model runs beside the design: a scalar program counter, a bubble flag and an 8-element rotating queue. The model is compared with the design on every cycle. Directed jumps use page latch values whose unused bits are set, which separates correct page-bit selection from an off-by-one slice. A jump to 1FFFh followed by an advance shows whether the counter wraps. Calls nested ten deep, followed by ten returns, show whether the stack overwrites its oldest entry and wraps on underflow, as opposed to saturating. Strobes raised during bubbles and in overlapping combinations test how commands are ignored and ranked. A long run of random command patterns then mixes all paths.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    localparam int PC_W   = 13;
    localparam int IMM_W  = 11;
    localparam int PAGE_W = 5;
    localparam int LIT_W  = 8;
    localparam int PG_W   = PC_W - IMM_W;

    typedef logic [PC_W-1:0] pc_t;

    // Command decoded from the strobe set for one cycle.
    typedef enum logic [2:0] {
        OP_IDLE   = 3'd0,
        OP_ADV    = 3'd1,
        OP_SKIP   = 3'd2,
        OP_JUMP   = 3'd3,
        OP_CALL   = 3'd4,
        OP_RET    = 3'd5,
        OP_RETLIT = 3'd6,
        OP_RETINT = 3'd7
    } op_e;

    // Raw strobes as they arrive from the instruction decoder.
    typedef struct packed {
        logic retint;
        logic retlit;
        logic ret;
        logic call;
        logic jump;
        logic skip;
        logic adv;
    } strobe_t;

    // Per-command properties driving the datapath.
    typedef struct packed {
        logic to_target;  // load page/immediate target
        logic from_stack; // load popped return address
        logic push;       // push return address
        logic two_cycle;  // follow with a bubble
        logic seq;        // add a sequential step
        logic [1:0] step; // size of the sequential step
    } op_attr_t;

    // Stack request for one cycle.
    typedef struct packed {
        logic push;
        logic pop;
        pc_t  val;
    } stk_req_t;

    function automatic op_attr_t op_attr(op_e op);
        op_attr_t a;
        a = '0;
        unique case (op)
            OP_ADV:    begin a.seq = 1'b1; a.step = 2'd1; end
            OP_SKIP:   begin a.seq = 1'b1; a.step = 2'd2; a.two_cycle = 1'b1; end
            OP_JUMP:   begin a.to_target = 1'b1; a.two_cycle = 1'b1; end
            OP_CALL:   begin a.to_target = 1'b1; a.push = 1'b1; a.two_cycle = 1'b1; end
            OP_RET,
            OP_RETLIT,
            OP_RETINT: begin a.from_stack = 1'b1; a.two_cycle = 1'b1; end
            default:   a = '0;
        endcase
        return a;
    endfunction

    function automatic pc_t page_target(logic [PG_W-1:0] pg, logic [IMM_W-1:0] imm);
        return {pg, imm};
    endfunction

endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
    import pcs_pkg::*;
(
    input  strobe_t strobe_i,
    input  logic    bubble_i,
    output op_e     op_o
);

    // Fixed priority; everything is masked during a bubble cycle.
    always_comb begin
        op_o = OP_IDLE;
        if (!bubble_i) begin
            if      (strobe_i.retint) op_o = OP_RETINT;
            else if (strobe_i.retlit) op_o = OP_RETLIT;
            else if (strobe_i.ret)    op_o = OP_RET;
            else if (strobe_i.call)   op_o = OP_CALL;
            else if (strobe_i.jump)   op_o = OP_JUMP;
            else if (strobe_i.skip)   op_o = OP_SKIP;
            else if (strobe_i.adv)    op_o = OP_ADV;
            else                      op_o = OP_IDLE;
        end
    end

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int DEPTH = 8,
    parameter int W     = 13
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] push_val_i,
    output logic [W-1:0] top_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] ptr_inc;
    logic [PTR_W-1:0] ptr_dec;
    logic [W-1:0]     ent_q [DEPTH];

    // Circular pointer: wraps both ways, no full/empty tracking.
    assign ptr_inc = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    assign ptr_dec = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    assign top_o   = ent_q[ptr_dec];

    always_ff @(posedge clk) begin
        if (rst)         ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_inc;
        else if (pop_i)  ptr_q <= ptr_dec;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)
                ent_q[i] <= '0;
            else if (push_i && (ptr_q == PTR_W'(i)))
                ent_q[i] <= push_val_i;
        end
    end

    // R12: a push and a pop never share a cycle
    p_excl_r12: assert property (@(posedge clk) disable iff (rst)
        !(push_i && pop_i));

    // R12: the pointer advances with wrap on push
    p_push_wrap_r12: assert property (@(posedge clk) disable iff (rst)
        push_i |=> ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1));

    // R12: the pointer retreats with wrap on pop
    p_pop_wrap_r12: assert property (@(posedge clk) disable iff (rst)
        pop_i |=> ptr_q == (($past(ptr_q) == '0) ? LAST : $past(ptr_q) - 1'b1));

    // R4: the pushed value is what a following pop would return
    p_push_top_r4: assert property (@(posedge clk) disable iff (rst)
        push_i |=> top_o == $past(push_val_i));

endmodule

// File: rtl/pcs_next_pc.sv
module pcs_next_pc
    import pcs_pkg::*;
(
    input  pcs_pkg::pc_t               pc_i,
    input  pcs_pkg::op_e               op_i,
    input  logic [pcs_pkg::IMM_W-1:0]  imm_i,
    input  logic [pcs_pkg::PG_W-1:0]   page_hi_i,
    input  pcs_pkg::pc_t               stk_top_i,
    output pcs_pkg::pc_t               pc_nxt_o,
    output logic                       bubble_nxt_o,
    output pcs_pkg::stk_req_t          stk_req_o
);

    op_attr_t attr;
    pc_t      seq_pc;
    pc_t      ret_addr;

    assign attr     = op_attr(op_i);
    assign seq_pc   = pc_i + pc_t'(attr.step);
    assign ret_addr = pc_i + pc_t'(1);

    always_comb begin
        if (attr.to_target)       pc_nxt_o = page_target(page_hi_i, imm_i);
        else if (attr.from_stack) pc_nxt_o = stk_top_i;
        else if (attr.seq)        pc_nxt_o = seq_pc;
        else                      pc_nxt_o = pc_i;
    end

    assign bubble_nxt_o  = attr.two_cycle;
    assign stk_req_o.push = attr.push;
    assign stk_req_o.pop  = attr.from_stack;
    assign stk_req_o.val  = ret_addr;

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
    import pcs_pkg::*;
#(
    parameter int STK_DEPTH = 8,
    parameter int PAGE_LO   = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv_i,
    input  logic                       skip_i,
    input  logic                       jump_i,
    input  logic                       call_i,
    input  logic                       ret_i,
    input  logic                       retlit_i,
    input  logic                       retint_i,
    input  logic [pcs_pkg::IMM_W-1:0]  imm_i,
    input  logic [pcs_pkg::PAGE_W-1:0] page_i,
    input  logic [pcs_pkg::LIT_W-1:0]  lit_i,
    output logic [pcs_pkg::PC_W-1:0]   fetch_addr_o,
    output logic                       wload_o,
    output logic [pcs_pkg::LIT_W-1:0]  wlit_o,
    output logic                       gie_set_o,
    output logic                       bubble_o
);

    strobe_t             strobe;
    op_e                 op;
    pc_t                 pc_q;
    pc_t                 pc_nxt;
    logic                bubble_q;
    logic                bubble_nxt;
    stk_req_t            stk_req;
    pc_t                 stk_top;
    logic [PG_W-1:0]     page_hi;
    logic                unused_page;

    assign strobe = '{retint: retint_i, retlit: retlit_i, ret: ret_i,
                      call: call_i, jump: jump_i, skip: skip_i, adv: adv_i};

    assign page_hi     = page_i[PAGE_LO +: PG_W];
    assign unused_page = ^page_i;

    pcs_decode u_decode (
        .strobe_i (strobe),
        .bubble_i (bubble_q),
        .op_o     (op)
    );

    pcs_next_pc u_next (
        .pc_i         (pc_q),
        .op_i         (op),
        .imm_i        (imm_i),
        .page_hi_i    (page_hi),
        .stk_top_i    (stk_top),
        .pc_nxt_o     (pc_nxt),
        .bubble_nxt_o (bubble_nxt),
        .stk_req_o    (stk_req)
    );

    pcs_ret_stack #(
        .DEPTH (STK_DEPTH),
        .W     (PC_W)
    ) u_stack (
        .clk        (clk),
        .rst        (rst),
        .push_i     (stk_req.push),
        .pop_i      (stk_req.pop),
        .push_val_i (stk_req.val),
        .top_o      (stk_top)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            bubble_q <= 1'b0;
        end else begin
            pc_q     <= pc_nxt;
            bubble_q <= bubble_nxt;
        end
    end

    assign fetch_addr_o = pc_q;
    assign bubble_o     = bubble_q;
    assign wload_o      = (op == OP_RETLIT);
    assign wlit_o       = wload_o ? lit_i : '0;
    assign gie_set_o    = (op == OP_RETINT);

    // R2: advance steps by one with modulo wrap
    p_adv_r2: assert property (@(posedge clk) disable iff (rst)
        (op == OP_ADV) |=> fetch_addr_o == $past(fetch_addr_o) + 1'b1 && !bubble_o);

    // R3: jump target from page bits and immediate
    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JUMP) |=> fetch_addr_o == {$past(page_i[PAGE_LO +: PG_W]), $past(imm_i)});

    // R8: skip moves two ahead
    p_skip_r8: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SKIP) |=> fetch_addr_o == $past(fetch_addr_o) + 2'd2);

    // R9: two-cycle commands are followed by a bubble
    p_two_cycle_r9: assert property (@(posedge clk) disable iff (rst)
        (op inside {OP_SKIP, OP_JUMP, OP_CALL, OP_RET, OP_RETLIT, OP_RETINT}) |=> bubble_o);

    // R9: a bubble lasts one cycle and holds the address
    p_bubble_one_r9: assert property (@(posedge clk) disable iff (rst)
        bubble_o |=> !bubble_o && fetch_addr_o == $past(fetch_addr_o));

    // R9: no side strobes during a bubble
    p_bubble_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        bubble_o |-> !wload_o && !gie_set_o);

    // R6: literal accompanies the load strobe only
    p_wlit_r6: assert property (@(posedge clk) disable iff (rst)
        wload_o ? (wlit_o == lit_i) : (wlit_o == '0));

    // R11: no strobe holds the address
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (!bubble_o && strobe == '0) |=> $stable(fetch_addr_o) && !bubble_o);

    // R10: side strobes are mutually exclusive
    p_one_side_r10: assert property (@(posedge clk) disable iff (rst)
        !(wload_o && gie_set_o));

endmodule

// File: tb/sim_pc_sequencer.sv
`timescale 1ns/100ps
module sim_pc_sequencer;

    localparam logic [6:0] S_ADV = 7'h01;
    localparam logic [6:0] S_SKP = 7'h02;
    localparam logic [6:0] S_JMP = 7'h04;
    localparam logic [6:0] S_CAL = 7'h08;
    localparam logic [6:0] S_RET = 7'h10;
    localparam logic [6:0] S_RTL = 7'h20;
    localparam logic [6:0] S_RTI = 7'h40;

    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  s;
    logic [10:0] imm;
    logic [4:0]  page;
    logic [7:0]  lit;
    logic [12:0] fetch_addr;
    logic        wload;
    logic [7:0]  wlit;
    logic        gie_set;
    logic        bubble;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state
    int   m_pc;
    bit   m_bub;
    int   stk[$];

    always #2.5 clk = ~clk;

    pc_sequencer u0 (
        .clk          (clk),
        .rst          (rst),
        .adv_i        (s[0]),
        .skip_i       (s[1]),
        .jump_i       (s[2]),
        .call_i       (s[3]),
        .ret_i        (s[4]),
        .retlit_i     (s[5]),
        .retint_i     (s[6]),
        .imm_i        (imm),
        .page_i       (page),
        .lit_i        (lit),
        .fetch_addr_o (fetch_addr),
        .wload_o      (wload),
        .wlit_o       (wlit),
        .gie_set_o    (gie_set),
        .bubble_o     (bubble)
    );

    task automatic do_pop(output int v);
        v = stk.pop_back();
        stk.push_front(v);
    endtask

    task automatic do_push(input int v);
        int drop;
        stk.push_back(v);
        drop = stk.pop_front();
    endtask

    // One instruction cycle: drive, compare, clock, advance the model.
    task automatic step(input logic [6:0] sv, input int im, input int pg,
                        input int lt, input string tag);
        bit    e_wl;
        bit    e_gie;
        int    e_lit;
        int    npc;
        bit    nbub;
        int    v;
        string t;
        s    = sv;
        imm  = im[10:0];
        page = pg[4:0];
        lit  = lt[7:0];
        e_wl  = 0;
        e_gie = 0;
        npc   = m_pc;
        nbub  = 0;
        t     = tag;
        if (m_bub) begin
            if (t == "") t = "R9";
        end else if (sv[6]) begin
            e_gie = 1; do_pop(v); npc = v; nbub = 1;
            if (t == "") t = "R7";
        end else if (sv[5]) begin
            e_wl = 1; do_pop(v); npc = v; nbub = 1;
            if (t == "") t = "R6";
        end else if (sv[4]) begin
            do_pop(v); npc = v; nbub = 1;
            if (t == "") t = "R5";
        end else if (sv[3]) begin
            do_push((m_pc + 1) % 8192);
            npc = (((pg >> 3) & 3) << 11) | (im & 11'h7FF); nbub = 1;
            if (t == "") t = "R4";
        end else if (sv[2]) begin
            npc = (((pg >> 3) & 3) << 11) | (im & 11'h7FF); nbub = 1;
            if (t == "") t = "R3";
        end else if (sv[1]) begin
            npc = (m_pc + 2) % 8192; nbub = 1;
            if (t == "") t = "R8";
        end else if (sv[0]) begin
            npc = (m_pc + 1) % 8192;
            if (t == "") t = "R2";
        end else begin
            if (t == "") t = "R11";
        end
        if (!m_bub && $countones(sv) > 1 && tag == "") t = "R10";
        e_lit = e_wl ? (lt & 8'hFF) : 0;
        #1;
        n_checks++;
        if (int'(fetch_addr) != m_pc || bubble != m_bub || wload != e_wl ||
            gie_set != e_gie || int'(wlit) != e_lit) begin
            n_fail++;
            $display("FAIL %s: addr=%h bub=%0d wl=%0d lit=%h gie=%0d expected addr=%h bub=%0d wl=%0d lit=%h gie=%0d",
                     t, fetch_addr, bubble, wload, wlit, gie_set,
                     m_pc, m_bub, e_wl, e_lit, e_gie);
        end
        @(posedge clk);
        m_pc  = npc;
        m_bub = nbub;
        @(negedge clk);
    endtask

    initial begin
        rst  = 1'b1;
        s    = '0;
        imm  = '0;
        page = '0;
        lit  = '0;
        m_pc  = 0;
        m_bub = 0;
        for (int i = 0; i < 8; i++) stk.push_back(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, then a pop from the cleared stack gives 0
        step(7'h00, 0, 0, 0, "R1");
        step(S_ADV, 0, 0, 0, "R1");
        step(S_RET, 0, 0, 0, "R1");
        step(7'h00, 0, 0, 0, "R1");

        // R2: sequential advance
        for (int i = 0; i < 5; i++) step(S_ADV, 0, 0, 0, "R2");
        // R11: idle holds
        step(7'h00, 0, 0, 0, "R11");
        step(7'h00, 0, 0, 0, "R11");

        // R3 + R2: jump to the top address, then wrap to zero
        step(S_JMP, 11'h7FF, 5'b11000, 0, "R3");
        step(S_CAL | S_RTL, 0, 0, 8'h3C, "R9");
        step(S_ADV, 0, 0, 0, "R2");
        step(S_ADV, 0, 0, 0, "R2");

        // R3: only page bits 4:3 matter
        step(S_JMP, 11'h123, 5'b01111, 0, "R3");
        step(7'h00, 0, 0, 0, "R9");
        step(S_JMP, 11'h456, 5'b10111, 0, "R3");
        step(S_RTI, 0, 0, 0, "R9");

        // R4 then R6
        step(S_CAL, 11'h055, 5'b10000, 0, "R4");
        step(S_ADV, 0, 0, 0, "R9");
        step(S_ADV, 0, 0, 0, "R4");
        step(S_RTL, 0, 0, 8'hA5, "R6");
        step(S_RTL, 0, 0, 8'h11, "R9");

        // R8: taken skip
        step(S_SKP, 0, 0, 0, "R8");
        step(S_ADV, 0, 0, 0, "R9");
        step(S_SKP, 0, 0, 0, "R8");
        step(7'h00, 0, 0, 0, "R9");

        // R7: call then return from interrupt
        step(S_CAL, 11'h700, 5'b01000, 0, "R4");
        step(7'h00, 0, 0, 0, "R9");
        step(S_RTI, 0, 0, 0, "R7");
        step(7'h00, 0, 0, 0, "R9");

        // R5: plain return
        step(S_CAL, 11'h010, 5'b00000, 0, "R4");
        step(7'h00, 0, 0, 0, "R9");
        step(S_ADV, 0, 0, 0, "R2");
        step(S_RET, 0, 0, 0, "R5");
        step(7'h00, 0, 0, 0, "R9");

        // R10: overlapping strobes
        step(S_ADV | S_JMP, 11'h222, 5'b01000, 0, "R10");
        step(7'h00, 0, 0, 0, "R9");
        step(S_SKP | S_ADV, 0, 0, 0, "R10");
        step(7'h00, 0, 0, 0, "R9");
        step(S_CAL | S_JMP, 11'h333, 5'b11000, 0, "R10");
        step(7'h00, 0, 0, 0, "R9");
        step(S_RTI | S_RTL | S_CAL, 0, 0, 8'h77, "R10");
        step(7'h00, 0, 0, 0, "R9");
        step(S_RTL | S_RET, 0, 0, 8'h5A, "R10");
        step(7'h00, 0, 0, 0, "R9");

        // R12: ten nested calls, then ten returns (overflow and underflow wrap)
        for (int i = 0; i < 10; i++) begin
            step(S_CAL, 11'h100 + i * 16, (i % 4) << 3, 0, "R12");
            step(7'h00, 0, 0, 0, "R12");
            step(S_ADV, 0, 0, 0, "R12");
        end
        for (int i = 0; i < 10; i++) begin
            step(S_RET, 0, 0, 0, "R12");
            step(7'h00, 0, 0, 0, "R12");
        end

        // Mixed random patterns
        for (int i = 0; i < 600; i++) begin
            logic [6:0] rs;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel < 7)       rs = 7'(1 << sel);
            else if (sel == 7) rs = 7'($urandom_range(0, 127));
            else               rs = 7'h00;
            step(rs, $urandom_range(0, 2047), $urandom_range(0, 31),
                 $urandom_range(0, 255), "");
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule